// File: doc/BRIEF.md
# Command-Pointer Port Expander Target

This block is a two-wire serial bus target that gives a bus controller access to an 8-bit general-purpose port. Four byte-wide registers sit behind a command byte: the pin level view, the drive values, a per-bit read inversion mask and the per-bit direction. The SCL and SDA lines are brought into the system clock domain through a two-flop synchroniser. Start, stop and clock edges are detected on the synchronised samples. SDA is never driven high: the block only asks the pad to pull it low.

The target address is a fixed prefix followed by three strap inputs. A write sends the address with the direction bit clear, then a command byte, then any number of data bytes. The command byte loads a register pointer. The pointer never advances by itself, so every data byte that follows, and every byte of every later read, goes to the same register until a new command byte arrives.

A read uses the address with the direction bit set. It is usually reached through a repeated START after a command byte. The pin outputs and the per-pin drive enables feed an external tristate or open-drain stage. The pin inputs carry the levels seen on the pads.

Top module: `i2c_port_expander`

## Requirements
- R1: The target responds only to the 7-bit address {4'b0100, strap_i[2:0]}, with bit 0 of the address byte being the direction (1 = read). Any other address receives no ACK and causes no register change.
- R2: After reset, pin_o is 0xFF, pin_oe is 0x00 (every pin an input), the inversion mask is 0x00 and the pointer is 0.
- R3: A write transaction (address+W, command byte, data bytes) is acknowledged on every byte. Each data byte goes into the register chosen by the pointer.
- R4: The pointer keeps its value across bytes and transactions. Several data bytes in one write all land in the same register, and repeated reads return that same register.
- R5: Pointer 0 reads back the pin level XOR the inversion mask (pointer 2), for every pin whatever its direction.
- R6: Data written with pointer 0 is ignored: pin_o and pin_oe and every readable register keep their values.
- R7: Pointer 1 is the drive register, which appears directly on pin_o. Pointer 3 is the direction register: bit value 1 makes a pin an input and 0 makes it an output, and pin_oe equals its inverse.
- R8: Command values above 3 are acknowledged. Data written with such a pointer is discarded, and reads with it return 0xFF.
- R9: During a read, a controller ACK makes the target send the next byte. A NACK makes it release SDA and stay released until a STOP or a repeated START, after which it again answers its address.
- R10: sda_oe changes only while the synchronised SCL is low. A START or STOP always leaves SDA released.
- R11: Pointers 1, 2 and 3 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Low three address bits |
| pin_i | input | 8 | Levels present on the port pins |
| pin_o | output | 8 | Drive value per pin |
| pin_oe | output | 8 | 1 enables the driver of that pin |

## Verification
The hardest case to reach is the read NACK boundary. A wrong design that ignores the NACK reloads the byte and pulls SDA low for its first zero bit. Telling that apart from a correct release needs a readback register with a clear top bit and a wait with SCL held low. The stimulus therefore reads the inversion mask after it is set to 0x3C and NACKs that byte. It then checks sda_oe during the idle gap, and issues a repeated START straight from that waiting state to prove the target recovers with its pointer intact. A second hard case is a write with pointer 0, which has to be shown to change nothing: the drive and direction outputs and a follow-up readback of the input view are compared after it.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam int PORT_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int PREFIX_W = 4;
  localparam int BYTE_W   = PORT_W;

  typedef logic [PORT_W-1:0] port_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_CMD, PH_CACK,
    PH_WDAT, PH_DACK, PH_TX, PH_TACK, PH_WAIT
  } phase_t;

  localparam port_t SEL_LEVEL  = port_t'(0);
  localparam port_t SEL_DRIVE  = port_t'(1);
  localparam port_t SEL_INVERT = port_t'(2);
  localparam port_t SEL_DIR    = port_t'(3);

  function automatic port_t level_view(port_t lvl, port_t inv);
    return lvl ^ inv;
  endfunction

  function automatic port_t read_pick(port_t sel, port_t lvl, port_t inv,
                                      port_t drv, port_t dir);
    case (sel)
      SEL_LEVEL:  return level_view(lvl, inv);
      SEL_DRIVE:  return drv;
      SEL_INVERT: return inv;
      SEL_DIR:    return dir;
      default:    return '1;
    endcase
  endfunction

  function automatic logic addr_match(logic [BYTE_W-1:0] frame,
                                      logic [PREFIX_W-1:0] pfx,
                                      logic [STRAP_W-1:0] strap);
    return frame[BYTE_W-1:1] == {pfx, strap};
  endfunction
endpackage

// File: rtl/exp_line_sync.sv
module exp_line_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/exp_bus_events.sv
module exp_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/exp_link.sv
module exp_link
  import exp_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  port_t              rd_data,
  output logic               sda_oe,
  output logic               cmd_stb,
  output logic               wr_stb,
  output port_t              rx_byte,
  output logic               link_idle
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  phase_t          phase;
  logic [BYTE_W-1:0] shreg;
  logic [CW-1:0]   cnt;
  logic            rw_q, nack_q, oe_q;
  logic            bus_evt, byte_end, addr_hit;

  assign bus_evt  = start_evt | stop_evt;
  assign byte_end = scl_fall && (cnt == FULL);
  assign addr_hit = addr_match(shreg, ADDR_PREFIX, strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      shreg  <= '0;
      cnt    <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_evt) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_evt) begin
      phase <= PH_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (phase)
        PH_ADDR, PH_CMD, PH_WDAT: begin
          if (scl_rise && cnt != FULL) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            if (phase == PH_ADDR) begin
              if (addr_hit) begin
                phase <= PH_AACK;
                oe_q  <= 1'b1;
                rw_q  <= shreg[0];
              end else begin
                phase <= PH_WAIT;
              end
            end else begin
              phase <= (phase == PH_CMD) ? PH_CACK : PH_DACK;
              oe_q  <= 1'b1;
            end
          end
        end
        PH_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              phase <= PH_TX;
              shreg <= rd_data;
              oe_q  <= ~rd_data[BYTE_W-1];
            end else begin
              phase <= PH_CMD;
              oe_q  <= 1'b0;
            end
          end
        end
        PH_CACK, PH_DACK: begin
          if (scl_fall) begin
            phase <= PH_WDAT;
            cnt   <= '0;
            oe_q  <= 1'b0;
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              phase <= PH_TACK;
              oe_q  <= 1'b0;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              oe_q  <= ~shreg[BYTE_W-2];
              cnt   <= cnt + 1'b1;
            end
          end
        end
        PH_TACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              phase <= PH_TX;
              shreg <= rd_data;
              oe_q  <= ~rd_data[BYTE_W-1];
              cnt   <= '0;
            end else begin
              phase <= PH_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign rx_byte   = shreg;
  assign cmd_stb   = !bus_evt && phase == PH_CMD  && byte_end;
  assign wr_stb    = !bus_evt && phase == PH_WDAT && byte_end;
  assign link_idle = (phase == PH_IDLE) || (phase == PH_WAIT);
endmodule

// File: rtl/exp_regs.sv
module exp_regs
  import exp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_stb,
  input  logic  wr_stb,
  input  port_t rx_byte,
  input  port_t pin_lvl,
  output port_t rd_data,
  output port_t pin_o,
  output port_t pin_oe,
  output port_t ptr
);
  port_t drv_q, inv_q, dir_q, ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '1;
      inv_q <= '0;
      dir_q <= '1;
      ptr_q <= '0;
    end else begin
      if (cmd_stb) ptr_q <= rx_byte;
      if (wr_stb) begin
        case (ptr_q)
          SEL_DRIVE:  drv_q <= rx_byte;
          SEL_INVERT: inv_q <= rx_byte;
          SEL_DIR:    dir_q <= rx_byte;
          default:    ;
        endcase
      end
    end
  end

  assign rd_data = read_pick(ptr_q, pin_lvl, inv_q, drv_q, dir_q);
  assign ptr     = ptr_q;

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    assign pin_o[b]  = drv_q[b];
    assign pin_oe[b] = ~dir_q[b];
  end
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander #(
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe
);
  import exp_pkg::*;

  localparam int SW = PORT_W + 2;

  logic [SW-1:0] sync_q;
  logic          scl_s, sda_s;
  port_t         pin_lvl;
  logic          scl_rise, scl_fall, start_evt, stop_evt;
  logic          cmd_stb, wr_stb, link_idle;
  port_t         rx_byte, rd_data, reg_ptr;

  exp_line_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pin_i, sda_i, scl_i}), .q(sync_q)
  );

  assign scl_s   = sync_q[0];
  assign sda_s   = sync_q[1];
  assign pin_lvl = sync_q[SW-1:2];

  exp_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  exp_link #(.ADDR_PREFIX(ADDR_PREFIX)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_oe),
    .cmd_stb(cmd_stb), .wr_stb(wr_stb), .rx_byte(rx_byte),
    .link_idle(link_idle)
  );

  exp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .wr_stb(wr_stb),
    .rx_byte(rx_byte), .pin_lvl(pin_lvl), .rd_data(rd_data),
    .pin_o(pin_o), .pin_oe(pin_oe), .ptr(reg_ptr)
  );
endmodule

// File: rtl/exp_checks.sv
module exp_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] wr_val,
  input logic [7:0] wr_ptr,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       link_idle
);
  AST_LEVEL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ptr == 8'd0) |=> ($stable(pin_o) && $stable(pin_oe))); // R6
  AST_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ptr == 8'd1) |=> (pin_o == $past(wr_val))); // R3
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ptr == 8'd3) |=> (pin_oe == ~$past(wr_val))); // R7
  AST_HIGH_PTR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ptr > 8'd3) |=> ($stable(pin_o) && $stable(pin_oe))); // R8
  AST_NO_SPURIOUS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(pin_o) && $stable(pin_oe))); // R4
  AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_BUS_EVT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |-> !sda_oe); // R9
endmodule

bind i2c_port_expander exp_checks i_exp_checks (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_val(rx_byte), .wr_ptr(reg_ptr),
  .pin_o(pin_o), .pin_oe(pin_oe), .start_evt(start_evt),
  .stop_evt(stop_evt), .link_idle(link_idle)
);

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] ext = 8'h5A;
  wire        sda_oe;
  wire  [7:0] pin_o, pin_oe;
  wire        sda_line = sda_m & ~sda_oe;
  wire  [7:0] pin_lvl  = (pin_o & pin_oe) | (ext & ~pin_oe);

  i2c_port_expander i_i2c_port_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .pin_i(pin_lvl),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // behavioural reference state
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_cfg = 8'hFF, m_ptr = 8'h00;
  int checks = 0, fails = 0, mon_pin_err = 0, mon_sda_err = 0;
  bit settled = 1'b0, done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] rbuf [4];

  function automatic logic [6:0] dev();
    return {4'b0100, strap};
  endfunction
  function automatic logic [7:0] m_level();
    return (m_out & ~m_cfg) | (ext & m_cfg);
  endfunction
  function automatic logic [7:0] m_read();
    if (m_ptr == 8'd0) return m_level() ^ m_pol;
    if (m_ptr == 8'd1) return m_out;
    if (m_ptr == 8'd2) return m_pol;
    if (m_ptr == 8'd3) return m_cfg;
    return 8'hFF;
  endfunction

  // per-clock comparison of outputs against the model
  always begin
    @(posedge clk); #1;
    if (rst_n && settled && (pin_o !== m_out || pin_oe !== ~m_cfg)) mon_pin_err++;
    if (rst_n && sda_oe !== oe_prev && scl_m) mon_sda_err++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask
  task automatic bus_restart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~mack; wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] cmd, input int n,
                        input logic [7:0] d0, input logic [7:0] d1,
                        output logic a_ack, output logic all_ack);
    logic ack;
    settled = 1'b0;
    bus_start();
    send_byte({a, 1'b0}, ack);
    a_ack = ack; all_ack = ack;
    if (ack) begin
      send_byte(cmd, ack); all_ack &= ack;
      for (int i = 0; i < n; i++) begin
        send_byte(i == 0 ? d0 : d1, ack); all_ack &= ack;
      end
    end
    bus_stop();
    if (a == dev()) begin
      m_ptr = cmd;
      for (int i = 0; i < n; i++) begin
        if (cmd == 8'd1) m_out = (i == 0) ? d0 : d1;
        if (cmd == 8'd2) m_pol = (i == 0) ? d0 : d1;
        if (cmd == 8'd3) m_cfg = (i == 0) ? d0 : d1;
      end
    end
    wq(4 * Q);
    settled = 1'b1;
  endtask

  task automatic rd_reg(input logic [7:0] cmd, input int n);
    logic ack;
    logic [7:0] b;
    settled = 1'b0;
    bus_start();
    send_byte({dev(), 1'b0}, ack);
    send_byte(cmd, ack);
    bus_restart();
    send_byte({dev(), 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
    m_ptr = cmd;
    wq(4 * Q);
    settled = 1'b1;
  endtask

  task automatic rd_cur(input int n);
    logic ack;
    logic [7:0] b;
    settled = 1'b0;
    bus_start();
    send_byte({dev(), 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
    wq(4 * Q);
    settled = 1'b1;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic aa, ok, ack;
    logic [7:0] b;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R2: reset values
    chk("R2 pin_o after reset", pin_o, 8'hFF);
    chk("R2 pin_oe after reset", pin_oe, 8'h00);
    settled = 1'b1;

    // R2 / R5: pointer 0 and zero mask after reset
    rd_cur(1);
    chk("R2 R5 read after reset", rbuf[0], 8'h5A);

    // R1: wrong strap value gets no ACK and changes nothing
    wr_reg({4'b0100, 3'b010}, 8'd3, 1, 8'h00, 8'h00, aa, ok);
    chk("R1 foreign address ack", {7'd0, aa}, 8'h00);
    chk("R1 foreign write ignored", pin_oe, 8'h00);

    // R3 / R7: direction register
    wr_reg(dev(), 8'd3, 1, 8'hF0, 8'h00, aa, ok);
    chk("R3 all bytes acked", {7'd0, ok}, 8'h01);
    chk("R7 pin_oe from direction", pin_oe, 8'h0F);

    wr_reg(dev(), 8'd1, 1, 8'hA5, 8'h00, aa, ok);
    chk("R7 pin_o from drive", pin_o, 8'hA5);

    // R5: level view with inversion, outputs included
    wr_reg(dev(), 8'd2, 1, 8'h3C, 8'h00, aa, ok);
    rd_reg(8'd0, 1);
    chk("R5 level xor mask", rbuf[0], m_read());
    ext = 8'hC3; wq(4 * Q);
    rd_cur(1);
    chk("R5 new pin levels", rbuf[0], m_read());

    // R11: readback of writable registers
    rd_reg(8'd2, 1); chk("R11 mask readback", rbuf[0], 8'h3C);
    rd_reg(8'd3, 1); chk("R11 direction readback", rbuf[0], 8'hF0);
    rd_reg(8'd1, 1); chk("R11 drive readback", rbuf[0], 8'hA5);

    // R6: writing the level view does nothing
    wr_reg(dev(), 8'd0, 1, 8'h00, 8'h00, aa, ok);
    chk("R6 write acked", {7'd0, ok}, 8'h01);
    chk("R6 pin_o kept", pin_o, 8'hA5);
    chk("R6 pin_oe kept", pin_oe, 8'h0F);
    rd_cur(1);
    chk("R6 level view kept", rbuf[0], m_read());

    // R4: several bytes land in one register; reads repeat it
    wr_reg(dev(), 8'd1, 2, 8'h11, 8'h22, aa, ok);
    chk("R4 last byte in drive", pin_o, 8'h22);
    rd_cur(3);
    chk("R4 read 0", rbuf[0], 8'h22);
    chk("R4 read 1", rbuf[1], 8'h22);
    chk("R4 read 2", rbuf[2], 8'h22);

    // R9: NACK releases SDA; repeated START from waiting state
    settled = 1'b0;
    bus_start();
    send_byte({dev(), 1'b0}, ack);
    send_byte(8'd2, ack);
    bus_restart();
    send_byte({dev(), 1'b1}, ack);
    recv_byte(1'b0, b);
    chk("R9 byte before nack", b, 8'h3C);
    wq(3 * Q);
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_restart();
    send_byte({dev(), 1'b1}, ack);
    chk("R9 address acked after restart", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, b);
    bus_stop();
    m_ptr = 8'd2;
    chk("R9 R4 pointer kept", b, 8'h3C);
    wq(4 * Q);
    settled = 1'b1;

    // R8: pointer above 3
    wr_reg(dev(), 8'd7, 1, 8'h00, 8'h00, aa, ok);
    chk("R8 high pointer acked", {7'd0, ok}, 8'h01);
    chk("R8 drive unchanged", pin_o, 8'h22);
    chk("R8 direction unchanged", pin_oe, 8'h0F);
    rd_cur(2);
    chk("R8 read 0", rbuf[0], 8'hFF);
    chk("R8 read 1", rbuf[1], 8'hFF);

    // R1: new straps move the address
    strap = 3'b010; wq(4 * Q);
    wr_reg({4'b0100, 3'b101}, 8'd1, 1, 8'h00, 8'h00, aa, ok);
    chk("R1 old address ignored", {7'd0, aa}, 8'h00);
    wr_reg(dev(), 8'd1, 1, 8'h96, 8'h00, aa, ok);
    chk("R1 new address acked", {7'd0, aa}, 8'h01);
    chk("R1 write at new address", pin_o, 8'h96);

    // R10 and R7: whole-run monitors
    chk("R10 sda_oe moved with SCL high", mon_sda_err[7:0], 8'h00);
    chk("R7 per-clock output compare", mon_pin_err[7:0], 8'h00);
    finish_up();
  end
endmodule